// File: doc/BRIEF.md
# MESI Snooping Cache Line Controller

This block keeps the coherence state of every line of a small write-back cache that shares a snooping bus with other masters. Each line is in one of four states: Invalid, Shared, Exclusive-clean or Modified. The processor side sends read, write and evict requests. A request is held off with a valid/ready handshake until any bus transaction it needs has been granted and completed.

The bus side has two roles. As a master, the block issues read, read-exclusive, upgrade and write-back commands. As a snooper, it watches other masters' commands. It drives the wired shared response when it holds a requested line, and raises a flush strobe when it must supply dirty data.

A read miss that finds no other holder installs the line as Exclusive-clean. A later write to that line then needs no bus transaction at all. The data array, replacement choice and bus arbitration live outside the block.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid, `busReq` is low and `busCmd` is 0 (none).
- R2: A processor read (`cpuOp`=0) to an Invalid line issues a bus read (`busCmd`=1). At `busDone` the line becomes Exclusive-clean if `busSharedIn` is low, and Shared if it is high.
- R3: A snooped bus read (`snpCmd`=1) asserts `snpShared` in the same cycle exactly when the addressed line is valid. An Exclusive-clean or Modified line then becomes Shared.
- R4: A processor write (`cpuOp`=1) to an Exclusive-clean line makes it Modified with no bus command.
- R5: A processor write to a Shared line issues an upgrade (`busCmd`=3), and a write to an Invalid line issues a read-exclusive (`busCmd`=2). Either way the line becomes Modified at `busDone`.
- R6: Reads that hit a valid line, and writes that hit a Modified line, complete with no bus command.
- R7: A snooped bus read to a Modified line asserts `snpFlush` in the same cycle and leaves the line Shared.
- R8: A snooped read-exclusive (`snpCmd`=2) makes any line Invalid. It asserts `snpFlush` only if the line was Modified.
- R9: A snooped upgrade (`snpCmd`=3) makes a Shared line Invalid.
- R10: If a pending upgrade loses its line to a snoop before the grant, the request continues as a read-exclusive on the same line.
- R11: `busReq` stays high, with `busCmd` and `busLine` unchanged, until `busGrant`. `cpuReady` stays low for a request that needs the bus until the cycle after `busDone`.
- R12: Evicting (`cpuOp`=2) a Modified line issues a write-back (`busCmd`=4) and leaves the line Invalid. Evicting a clean line makes it Invalid with no bus command.
- R13: A processor request whose line is snooped in the same cycle is not accepted in that cycle, and the snoop transition takes effect first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpuValid | input | 1 | Processor request valid |
| cpuReady | output | 1 | Processor request accepted this cycle |
| cpuOp | input | 2 | 0 read, 1 write, 2 evict, 3 no-op |
| cpuLine | input | IDX_W | Line index of the processor request |
| busReq | output | 1 | Bus ownership request |
| busGrant | input | 1 | Bus granted to this master |
| busCmd | output | 3 | 0 none, 1 read, 2 read-exclusive, 3 upgrade, 4 write-back |
| busLine | output | IDX_W | Line index of the issued command |
| busDone | input | 1 | Issued transaction completes |
| busSharedIn | input | 1 | Wired shared signal sampled at completion |
| snpValid | input | 1 | Another master's command is on the bus |
| snpCmd | input | 3 | Snooped command, same encoding as busCmd |
| snpLine | input | IDX_W | Snooped line index |
| snpShared | output | 1 | This cache holds the snooped line (bus read) |
| snpFlush | output | 1 | This cache supplies dirty data for the snoop |

## Verification
The hardest case to reach from the ports is a pending upgrade that loses its line before the grant arrives. The bench starts a write to a Shared line and withholds `busGrant` for several cycles, which also shows that the request is held. While the request waits, the bench injects a snooped read-exclusive to the same line. It then checks that the offered command has become a read-exclusive, and that a later snoop sees the line as Modified.

A second hard case is a snoop that lands in the same cycle as a processor hit. The bench drives both on one negative edge and shows that the write did not take effect, because the next write to the line needs an upgrade.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

  typedef enum logic [1:0] {
    ST_INV = 2'd0,
    ST_SHR = 2'd1,
    ST_EXC = 2'd2,
    ST_MOD = 2'd3
  } mesi_state_e;

  typedef enum logic [2:0] {
    BC_NONE = 3'd0,
    BC_READ = 3'd1,
    BC_RDX  = 3'd2,
    BC_UPGR = 3'd3,
    BC_WB   = 3'd4
  } bus_cmd_e;

  typedef enum logic [1:0] {
    OP_RD  = 2'd0,
    OP_WR  = 2'd1,
    OP_EV  = 2'd2,
    OP_NOP = 2'd3
  } cpu_op_e;

  // control -> state store
  typedef struct packed {
    logic        setEn;     // write a new state into one line
    logic        useHit;    // 1: line is cpuLine, 0: line is the pending bus line
    mesi_state_e setState;
  } line_strobe_t;

  function automatic mesi_state_e snoopNext(mesi_state_e cur, bus_cmd_e cmd);
    mesi_state_e nxt;
    nxt = cur;
    case (cmd)
      BC_READ: nxt = (cur == ST_INV) ? ST_INV : ST_SHR;
      BC_RDX:  nxt = ST_INV;
      BC_UPGR: nxt = (cur == ST_SHR) ? ST_INV : cur;
      default: nxt = cur;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
  import mesi_pkg::*;
#(
  parameter int LINES = 4,
  parameter int IDX_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  line_strobe_t      strb,
  input  logic [IDX_W-1:0]  cpuLine,
  input  logic [IDX_W-1:0]  pendLine,
  input  logic              snpValid,
  input  logic [2:0]        snpCmd,
  input  logic [IDX_W-1:0]  snpLine,
  output mesi_state_e       cpuState,
  output mesi_state_e       pendState,
  output logic              snpShared,
  output logic              snpFlush
);

  mesi_state_e lineState [LINES];
  bus_cmd_e    snpCmdE;
  logic [IDX_W-1:0] setLine;

  assign snpCmdE = bus_cmd_e'(snpCmd);
  assign setLine = strb.useHit ? cpuLine : pendLine;

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic snpHit;
    assign snpHit = snpValid && (snpLine == IDX_W'(i));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lineState[i] <= ST_INV;
      end else if (snpHit) begin
        lineState[i] <= snoopNext(lineState[i], snpCmdE);
      end else if (strb.setEn && setLine == IDX_W'(i)) begin
        lineState[i] <= strb.setState;
      end
    end
  end

  assign cpuState  = lineState[cpuLine];
  assign pendState = lineState[pendLine];

  always_comb begin
    snpShared = 1'b0;
    snpFlush  = 1'b0;
    if (snpValid) begin
      snpShared = (snpCmdE == BC_READ) && (lineState[snpLine] != ST_INV);
      snpFlush  = (lineState[snpLine] == ST_MOD) &&
                  (snpCmdE == BC_READ || snpCmdE == BC_RDX);
    end
  end

  // R8
  rdx_inval_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snpValid && snpCmdE == BC_RDX |=> lineState[$past(snpLine)] == ST_INV);

  // R7
  mod_read_to_shared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snpValid && snpCmdE == BC_READ && snpFlush |=> lineState[$past(snpLine)] == ST_SHR);

  // R3
  shared_only_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snpShared |-> snpValid && snpCmdE == BC_READ);

endmodule

// File: rtl/mesi_ctrl.sv
module mesi_ctrl
  import mesi_pkg::*;
#(
  parameter int IDX_W       = 2,
  parameter bit USE_UPGRADE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpuValid,
  input  logic [1:0]        cpuOp,
  input  logic [IDX_W-1:0]  cpuLine,
  output logic              cpuReady,
  output logic              busReq,
  input  logic              busGrant,
  output logic [2:0]        busCmd,
  output logic [IDX_W-1:0]  busLine,
  input  logic              busDone,
  input  logic              busSharedIn,
  input  logic              snpValid,
  input  logic [IDX_W-1:0]  snpLine,
  input  mesi_state_e       cpuState,
  input  mesi_state_e       pendState,
  output line_strobe_t      strb
);

  typedef enum logic [1:0] {C_IDLE, C_REQ, C_XFER, C_DONE} ctrl_state_e;

  ctrl_state_e      ctrlState;
  bus_cmd_e         pendCmd, effCmd, needCmd;
  logic [IDX_W-1:0] pendLine;
  mesi_state_e      hitNext, doneNext;
  logic             clash, accept, hitAccept;

  // write-path miss on a Shared line: upgrade or full read-exclusive
  localparam bus_cmd_e SHR_WR_CMD = USE_UPGRADE ? BC_UPGR : BC_RDX;

  assign clash = snpValid && (snpLine == cpuLine);
  assign accept = (ctrlState == C_IDLE) && cpuValid && !clash;

  always_comb begin
    needCmd = BC_NONE;
    hitNext = cpuState;
    case (cpu_op_e'(cpuOp))
      OP_RD: if (cpuState == ST_INV) needCmd = BC_READ;
      OP_WR: begin
        case (cpuState)
          ST_MOD, ST_EXC: hitNext = ST_MOD;
          ST_SHR:         needCmd = SHR_WR_CMD;
          default:        needCmd = BC_RDX;
        endcase
      end
      OP_EV: begin
        if (cpuState == ST_MOD) needCmd = BC_WB;
        else                    hitNext = ST_INV;
      end
      default: hitNext = cpuState;
    endcase
  end

  assign hitAccept = accept && (needCmd == BC_NONE);

  // an upgrade whose line was snooped away must fetch the line again
  assign effCmd = (pendCmd == BC_UPGR && pendState == ST_INV) ? BC_RDX : pendCmd;

  always_comb begin
    case (effCmd)
      BC_READ:        doneNext = busSharedIn ? ST_SHR : ST_EXC;
      BC_RDX, BC_UPGR: doneNext = ST_MOD;
      default:        doneNext = ST_INV;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrlState <= C_IDLE;
      pendCmd   <= BC_NONE;
      pendLine  <= '0;
    end else begin
      case (ctrlState)
        C_IDLE: if (accept && needCmd != BC_NONE) begin
          pendCmd   <= needCmd;
          pendLine  <= cpuLine;
          ctrlState <= C_REQ;
        end
        C_REQ: begin
          pendCmd <= effCmd;
          if (busGrant) ctrlState <= C_XFER;
        end
        C_XFER: if (busDone) ctrlState <= C_DONE;
        default: ctrlState <= C_IDLE;
      endcase
    end
  end

  assign cpuReady = hitAccept || (ctrlState == C_DONE);
  assign busReq   = (ctrlState == C_REQ);
  assign busCmd   = (ctrlState == C_REQ || ctrlState == C_XFER) ? effCmd : BC_NONE;
  assign busLine  = pendLine;

  always_comb begin
    strb.setEn    = hitAccept || (ctrlState == C_XFER && busDone);
    strb.useHit   = hitAccept;
    strb.setState = hitAccept ? hitNext : doneNext;
  end

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busReq && !busGrant |=> busReq && $stable(busLine));

  // R11
  no_ready_while_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busReq |-> !cpuReady);

  // R10
  upgr_only_shared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busReq && busCmd == BC_UPGR |-> pendState == ST_SHR);

  // R13
  clash_no_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpuValid && clash |-> !(strb.setEn && strb.useHit));

endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
  import mesi_pkg::*;
#(
  parameter int  LINES       = 4,
  parameter bit  USE_UPGRADE = 1'b1,
  localparam int IDX_W       = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpuValid,
  output logic             cpuReady,
  input  logic [1:0]       cpuOp,
  input  logic [IDX_W-1:0] cpuLine,
  output logic             busReq,
  input  logic             busGrant,
  output logic [2:0]       busCmd,
  output logic [IDX_W-1:0] busLine,
  input  logic             busDone,
  input  logic             busSharedIn,
  input  logic             snpValid,
  input  logic [2:0]       snpCmd,
  input  logic [IDX_W-1:0] snpLine,
  output logic             snpShared,
  output logic             snpFlush
);

  line_strobe_t strb;
  mesi_state_e  cpuState, pendState;

  mesi_ctrl #(.IDX_W(IDX_W), .USE_UPGRADE(USE_UPGRADE)) ctrl_i (
    .clk, .rst_n, .cpuValid, .cpuOp, .cpuLine, .cpuReady,
    .busReq, .busGrant, .busCmd, .busLine, .busDone, .busSharedIn,
    .snpValid, .snpLine, .cpuState, .pendState, .strb
  );

  mesi_line_store #(.LINES(LINES), .IDX_W(IDX_W)) store_i (
    .clk, .rst_n, .strb, .cpuLine, .pendLine(busLine),
    .snpValid, .snpCmd, .snpLine, .cpuState, .pendState, .snpShared, .snpFlush
  );

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> !busReq && busCmd == 3'd0);

endmodule

// File: tb/mesi_line_ctrl_tb_top.sv
`timescale 1ns/1ps
module mesi_line_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpuValid = 1'b0, cpuReady;
  logic [1:0] cpuOp = 2'd0, cpuLine = 2'd0;
  logic       busReq, busGrant = 1'b0, busDone = 1'b0, busSharedIn = 1'b0;
  logic [2:0] busCmd;
  logic [1:0] busLine;
  logic       snpValid = 1'b0;
  logic [2:0] snpCmd = 3'd0;
  logic [1:0] snpLine = 2'd0;
  logic       snpShared, snpFlush;

  int testsRun = 0, testsFailed = 0, cycleCount = 0;

  always #5 clk = ~clk;

  mesi_line_ctrl #(.LINES(4)) dut_i (
    .clk, .rst_n, .cpuValid, .cpuReady, .cpuOp, .cpuLine,
    .busReq, .busGrant, .busCmd, .busLine, .busDone, .busSharedIn,
    .snpValid, .snpCmd, .snpLine, .snpShared, .snpFlush
  );

  // cpu ops / bus commands
  localparam logic [2:0] RD = 3'd0, WR = 3'd1, EV = 3'd2;
  localparam logic [2:0] NONE = 3'd0, BRD = 3'd1, RDX = 3'd2, UPG = 3'd3, WB = 3'd4;

  // {isSnoop, code, line, sharedIn, expCmd, expShared, expFlush}
  localparam int VW = 12;
  localparam int NV = 28;
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b0, RD,  2'd0, 1'b0, BRD,  1'b0, 1'b0}, // R2 miss, no sharer -> E
    {1'b1, BRD, 2'd0, 1'b0, NONE, 1'b1, 1'b0}, // R3 E snooped -> S
    {1'b0, WR,  2'd0, 1'b0, UPG,  1'b0, 1'b0}, // R5 S write -> upgrade
    {1'b0, RD,  2'd0, 1'b0, NONE, 1'b0, 1'b0}, // R6 read hit M
    {1'b0, WR,  2'd0, 1'b0, NONE, 1'b0, 1'b0}, // R6 write hit M
    {1'b1, BRD, 2'd0, 1'b0, NONE, 1'b1, 1'b1}, // R7 M flush -> S
    {1'b1, BRD, 2'd0, 1'b0, NONE, 1'b1, 1'b0}, // R7 now S, no flush
    {1'b0, RD,  2'd0, 1'b0, NONE, 1'b0, 1'b0}, // R6 read hit S
    {1'b0, RD,  2'd1, 1'b1, BRD,  1'b0, 1'b0}, // R2 miss with sharer -> S
    {1'b0, WR,  2'd1, 1'b0, UPG,  1'b0, 1'b0}, // R5 S -> M via upgrade
    {1'b1, RDX, 2'd1, 1'b0, NONE, 1'b0, 1'b1}, // R8 M flush -> I
    {1'b1, BRD, 2'd1, 1'b0, NONE, 1'b0, 1'b0}, // R8 now invalid
    {1'b0, RD,  2'd2, 1'b0, BRD,  1'b0, 1'b0}, // R2 -> E
    {1'b0, WR,  2'd2, 1'b0, NONE, 1'b0, 1'b0}, // R4 E -> M silently
    {1'b1, BRD, 2'd2, 1'b0, NONE, 1'b1, 1'b1}, // R4 confirms M
    {1'b0, WR,  2'd2, 1'b0, UPG,  1'b0, 1'b0}, // R5 S -> M
    {1'b0, EV,  2'd2, 1'b0, WB,   1'b0, 1'b0}, // R12 dirty evict
    {1'b1, BRD, 2'd2, 1'b0, NONE, 1'b0, 1'b0}, // R12 now invalid
    {1'b0, RD,  2'd3, 1'b0, BRD,  1'b0, 1'b0}, // R2 -> E
    {1'b0, EV,  2'd3, 1'b0, NONE, 1'b0, 1'b0}, // R12 clean evict silent
    {1'b1, BRD, 2'd3, 1'b0, NONE, 1'b0, 1'b0}, // R12 now invalid
    {1'b0, WR,  2'd3, 1'b0, RDX,  1'b0, 1'b0}, // R5 I write -> RDX
    {1'b1, BRD, 2'd3, 1'b0, NONE, 1'b1, 1'b1}, // R5 line is M
    {1'b1, UPG, 2'd3, 1'b0, NONE, 1'b0, 1'b0}, // R9 S snooped upgrade -> I
    {1'b1, BRD, 2'd3, 1'b0, NONE, 1'b0, 1'b0}, // R9 confirms I
    {1'b0, RD,  2'd1, 1'b0, BRD,  1'b0, 1'b0}, // R2 -> E
    {1'b1, RDX, 2'd1, 1'b0, NONE, 1'b0, 1'b0}, // R8 E -> I, no flush
    {1'b1, BRD, 2'd1, 1'b0, NONE, 1'b0, 1'b0}  // R8 confirms I
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at negedge+1 with busReq high; finishes the transfer
  task automatic grantDone(input logic shr, output logic [2:0] seen);
    seen = busCmd;
    busGrant = 1'b1;
    @(posedge clk);
    @(negedge clk);
    busGrant = 1'b0; busDone = 1'b1; busSharedIn = shr;
    @(posedge clk);
    @(negedge clk);
    busDone = 1'b0; busSharedIn = 1'b0;
    #1;
  endtask

  task automatic doCpu(input logic [2:0] op, input logic [1:0] ln, input logic shr,
                       output logic [2:0] seen);
    int waitCnt;
    seen = NONE;
    @(negedge clk);
    cpuValid = 1'b1; cpuOp = op[1:0]; cpuLine = ln;
    #1;
    waitCnt = 0;
    while (!cpuReady && !busReq && waitCnt < 20) begin
      @(negedge clk); #1; waitCnt++;
    end
    if (busReq) grantDone(shr, seen);
    check(cpuReady == 1'b1, "R11 ready after completion", cpuReady, 1);
    @(posedge clk);
    #1;
    cpuValid = 1'b0;
  endtask

  task automatic doSnoop(input logic [2:0] cmd, input logic [1:0] ln,
                         output logic sh, output logic fl);
    @(negedge clk);
    snpValid = 1'b1; snpCmd = cmd; snpLine = ln;
    #1;
    sh = snpShared; fl = snpFlush;
    @(posedge clk);
    #1;
    snpValid = 1'b0;
  endtask

  always @(posedge clk) begin
    cycleCount++;
    if (cycleCount > 100000) begin
      testsFailed++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    logic [2:0] seen;
    logic sh, fl;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    check(busReq == 1'b0, "R1 busReq in reset", busReq, 0);
    check(busCmd == NONE, "R1 busCmd in reset", busCmd, 0);
    @(negedge clk); rst_n = 1'b1;
    for (int l = 0; l < 4; l++) begin
      doSnoop(BRD, 2'(l), sh, fl);
      check(sh == 1'b0 && fl == 1'b0, "R1 line invalid after reset", {sh, fl}, 0);
    end

    for (int v = 0; v < NV; v++) begin
      logic [VW-1:0] e;
      e = VEC[v];
      if (e[11]) begin
        doSnoop(e[10:8], e[7:6], sh, fl);
        check(sh == e[1], $sformatf("R3/R8 vector %0d snpShared", v), sh, e[1]);
        check(fl == e[0], $sformatf("R7/R8 vector %0d snpFlush", v), fl, e[0]);
      end else begin
        doCpu(e[10:8], e[7:6], e[5], seen);
        check(seen == e[4:2], $sformatf("R2/R5/R6 vector %0d busCmd", v), seen, e[4:2]);
      end
    end

    // R13: write hit on E clashing with a snooped read on the same line
    doCpu(RD, 2'd1, 1'b0, seen);                  // line 1 -> E
    @(negedge clk);
    cpuValid = 1'b1; cpuOp = 2'd1; cpuLine = 2'd1;
    snpValid = 1'b1; snpCmd = BRD; snpLine = 2'd1;
    #1;
    check(cpuReady == 1'b0, "R13 clash not accepted", cpuReady, 0);
    check(snpShared == 1'b1, "R13 snoop sees line", snpShared, 1);
    @(posedge clk); #1;
    cpuValid = 1'b0; snpValid = 1'b0;
    doCpu(WR, 2'd1, 1'b0, seen);
    check(seen == UPG, "R13 snoop applied first, write needs upgrade", seen, UPG);

    // R10/R11: pending upgrade loses its line before grant
    doCpu(RD, 2'd2, 1'b1, seen);                  // line 2 -> S
    @(negedge clk);
    cpuValid = 1'b1; cpuOp = 2'd1; cpuLine = 2'd2;
    @(negedge clk); #1;
    check(busReq == 1'b1, "R11 request raised", busReq, 1);
    check(busCmd == UPG, "R10 initial upgrade", busCmd, UPG);
    repeat (3) @(negedge clk);
    #1;
    check(busReq == 1'b1 && busLine == 2'd2, "R11 request held without grant", busReq, 1);
    check(cpuReady == 1'b0, "R11 cpu stalled", cpuReady, 0);
    snpValid = 1'b1; snpCmd = RDX; snpLine = 2'd2;
    @(posedge clk); #1;
    snpValid = 1'b0;
    @(negedge clk); #1;
    check(busCmd == RDX, "R10 restart as read-exclusive", busCmd, RDX);
    grantDone(1'b0, seen);
    check(seen == RDX, "R10 granted command", seen, RDX);
    check(cpuReady == 1'b1, "R11 ready after done", cpuReady, 1);
    @(posedge clk); #1;
    cpuValid = 1'b0;
    doSnoop(BRD, 2'd2, sh, fl);
    check(fl == 1'b1, "R10 line modified after restart", fl, 1);

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule